// File: doc/BRIEF.md
# Serial Control-Register Port

This block is a slave serial port that gives an external host read and write access to a bank of thirty-two 8-bit control registers. All port logic runs on the serial clock. An active-low chip select frames each access. Each access begins with one instruction byte, which carries the direction, the number of data bytes and a start address. The data bytes follow. Over a multibyte access an internal address counter steps on its own.

Register 0 configures the port itself. One bit picks the bit order: most-significant-bit first or least-significant-bit first. Another bit picks the wiring: read data can come out on a separate data-out pin (4-wire) or be turned back onto the data-in line (3-wire). A third bit requests a software reset of the rest of the bank. A new configuration acts from the very next bit, even in the middle of an access. The low three bits of register 0 are mirrors of its top three, so a palindromic byte can restore the port from any unknown state. Tri-state pads are modelled as a data/enable pair per pin. The whole bank is also driven out in parallel for the chip logic that uses it.

Top module: `spreg_port`

## Requirements
- R1: While `rst` is high on a rising `sclk` edge, register 0 becomes 00h and register k (k = 1..31) becomes (17*k) mod 256. The transfer state returns to "expecting an instruction byte", and neither output enable is asserted.
- R2: Input bits on `sdio_i` are sampled on rising `sclk` edges, and read data is launched on falling edges. While `cs_n` is high, `sdio_oe` and `sdo_oe` are both 0.
- R3: The instruction byte, as assembled, holds: bit 7 = direction (1 read, 0 write), bits 6:5 = byte count minus one, bits 4:0 = start register address. Write data lands in the addressed register, and read data returns the register contents.
- R4: With register 0 bit 7 = 0 (4-wire), read data appears on `sdo_o` with `sdo_oe`=1 and `sdio_oe`=0. With bit 7 = 1 (3-wire), read data appears on `sdio_o` with `sdio_oe`=1, and `sdo_oe` stays 0. No enable is high during an instruction byte or a write.
- R5: An access moves exactly the counted number of data bytes. Any bits clocked in after that, before `cs_n` rises, change no register and drive no output.
- R6: With register 0 bit 6 = 0, every byte, the instruction included, travels most significant bit first, and the address decrements after each data byte, wrapping from 00h to 1Fh. With bit 6 = 1, bytes travel least significant bit first, and the address increments, wrapping from 1Fh to 00h.
- R7: If `cs_n` rises part-way through a byte, the partial byte is discarded and no register changes. The next access starts with a fresh instruction byte.
- R8: A write to register 0 stores bits 7:3 as sent, and sets bit 2 = bit 5, bit 1 = bit 6, bit 0 = bit 7. The new bit order, wiring and address-step direction apply from the next bit of the same access.
- R9: Register 0 bit 5 is a software reset. On the rising edge after it is written as 1, registers 1..31 return to their R1 defaults, and bits 5 and 2 of register 0 clear. All other bits of register 0 keep their values.
- R10: The instruction byte 00h followed by a palindromic data byte (pattern XY?00?YX) has the same effect whichever bit order the host uses. This re-establishes the configuration from an unknown port state.
- R11: `regs_flat[8*k+7:8*k]` always shows the current value of register k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; all port state updates on its edges |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select framing an access |
| sdio_i | input | 1 | Serial data in |
| sdio_o | output | 1 | Read data turned back onto the data-in line (3-wire) |
| sdio_oe | output | 1 | Drive enable for the data-in line |
| sdo_o | output | 1 | Read data on the separate data-out pin (4-wire) |
| sdo_oe | output | 1 | Drive enable for the data-out pin |
| regs_flat | output | 256 | Parallel view of all 32 registers, register k at bits 8k+7:8k |

## Verification
The bench goes after the places where a port like this usually breaks.

- **Configuration change mid-access.** The bench writes register 0 mid-access. A design that latched its configuration at the start would take the following byte in the wrong order and step the address the wrong way. A wrong byte then lands in the wrong register.
- **Address wrap.** Multibyte accesses cross the 00h/1Fh boundary in both directions. A counter of the wrong width, or stepping the wrong way, shows up as corruption of a distant register.
- **Aborted bytes.** Chip select is raised part-way through a byte. A design that committed partial bytes would alter the target.
- **Over-long accesses.** The host clocks on past the counted length. A design without a done phase would write the next address.
- **Reset and recovery.** The software reset is checked to clear every register except register 0. The palindromic recovery write is sent in the opposite bit order from the one the port is using, and must still restore a known configuration.

// File: rtl/spreg_pkg.sv
package spreg_pkg;

    localparam int DW   = 8;
    localparam int NREG = 32;
    localparam int AW   = $clog2(NREG);
    localparam int BW   = $clog2(DW);

    // register 0 field positions
    localparam int B_3W  = 7;
    localparam int B_LSB = 6;
    localparam int B_RST = 5;

    typedef enum logic [1:0] {
        PH_INSTR = 2'd0,
        PH_DATA  = 2'd1,
        PH_DONE  = 2'd2
    } phase_e;

    typedef struct packed {
        logic          rw;
        logic [1:0]    cnt;
        logic [AW-1:0] addr;
    } instr_t;

    typedef struct packed {
        logic three_wire;
        logic lsb_first;
        logic soft_rst;
    } port_cfg_t;

    function automatic logic [DW-1:0] reg_default(input int k);
        logic [31:0] v;
        v = 32'(k) * 32'd17;
        return (k == 0) ? '0 : v[DW-1:0];
    endfunction

    function automatic logic [DW-1:0] mirror_cfg(input logic [DW-1:0] w);
        return {w[7:3], w[5], w[6], w[7]};
    endfunction

    function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a, input logic lsb);
        return lsb ? a + AW'(1) : a - AW'(1);
    endfunction

    function automatic port_cfg_t decode_cfg(input logic [DW-1:0] r);
        port_cfg_t c;
        c.three_wire = r[B_3W];
        c.lsb_first  = r[B_LSB];
        c.soft_rst   = r[B_RST];
        return c;
    endfunction

endpackage

// File: rtl/spreg_bank.sv
module spreg_bank
    import spreg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [DW-1:0]       wr_data,
    input  logic [AW-1:0]       rd_addr,
    output logic [DW-1:0]       rd_data,
    output logic [DW-1:0]       cfg_byte,
    output logic [NREG*DW-1:0]  regs_flat
);

    logic [DW-1:0] mem [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NREG; k++) begin
                mem[k] <= reg_default(k);
            end
        end else if (mem[0][B_RST]) begin
            // software reset: everything but register 0 to defaults, then self-clear
            for (int k = 1; k < NREG; k++) begin
                mem[k] <= reg_default(k);
            end
            mem[0][B_RST] <= 1'b0;
            mem[0][2]     <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == '0) begin
                mem[0] <= mirror_cfg(wr_data);
            end else begin
                mem[wr_addr] <= wr_data;
            end
        end
    end

    assign rd_data  = mem[rd_addr];
    assign cfg_byte = mem[0];

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign regs_flat[g*DW +: DW] = mem[g];
    end

    // R9: reset request bit is gone one edge after it appears
    a_r9_reset_self_clears: assert property (@(posedge clk) disable iff (rst)
        mem[0][B_RST] |=> !mem[0][B_RST]);

    // R9: the bank is at defaults one edge after the request
    a_r9_defaults_restored: assert property (@(posedge clk) disable iff (rst)
        mem[0][B_RST] |=> (mem[1] == reg_default(1)) && (mem[NREG-1] == reg_default(NREG-1)));

    // R8: low bits of register 0 always mirror the top bits
    a_r8_cfg_mirrored: assert property (@(posedge clk) disable iff (rst)
        (mem[0][0] == mem[0][7]) && (mem[0][1] == mem[0][6]) && (mem[0][2] == mem[0][5]));

endmodule

// File: rtl/spreg_ctrl.sv
module spreg_ctrl
    import spreg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cs_n,
    input  logic            din,
    input  port_cfg_t       cfg,
    output logic            wr_en,
    output logic [AW-1:0]   wr_addr,
    output logic [DW-1:0]   wr_data,
    output logic [AW-1:0]   rd_addr,
    output logic            tx_load,
    output phase_e          phase,
    output logic [BW-1:0]   bitcnt,
    output logic            rd_mode
);

    logic [DW-1:0] sh_q;
    logic [DW-1:0] asm_w;
    phase_e        ph_q;
    logic [BW-1:0] cnt_q;
    logic          rw_q;
    logic [1:0]    left_q;
    logic [AW-1:0] addr_q;
    instr_t        ins_w;
    logic          last_w;
    logic          active_w;
    logic          lsb_next;

    always_comb begin
        asm_w    = cfg.lsb_first ? {din, sh_q[DW-1:1]} : {sh_q[DW-2:0], din};
        ins_w    = instr_t'(asm_w);
        last_w   = (cnt_q == BW'(DW-1));
        active_w = !cs_n && !rst;
        wr_en    = active_w && (ph_q == PH_DATA) && last_w && !rw_q;
        wr_addr  = addr_q;
        wr_data  = asm_w;
        // a register 0 write steers the rest of this access immediately
        lsb_next = (wr_en && addr_q == '0) ? asm_w[B_LSB] : cfg.lsb_first;
        rd_addr  = (ph_q == PH_INSTR) ? ins_w.addr : step_addr(addr_q, lsb_next);
        tx_load  = active_w && last_w &&
                   (((ph_q == PH_INSTR) && ins_w.rw) ||
                    ((ph_q == PH_DATA) && rw_q && (left_q != 2'd0)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_INSTR;
            cnt_q  <= '0;
            sh_q   <= '0;
            rw_q   <= 1'b0;
            left_q <= '0;
            addr_q <= '0;
        end else if (cs_n) begin
            ph_q  <= PH_INSTR;
            cnt_q <= '0;
            sh_q  <= '0;
        end else begin
            case (ph_q)
                PH_INSTR: begin
                    cnt_q <= cnt_q + BW'(1);
                    sh_q  <= asm_w;
                    if (last_w) begin
                        rw_q   <= ins_w.rw;
                        left_q <= ins_w.cnt;
                        addr_q <= ins_w.addr;
                        ph_q   <= PH_DATA;
                    end
                end
                PH_DATA: begin
                    cnt_q <= cnt_q + BW'(1);
                    sh_q  <= asm_w;
                    if (last_w) begin
                        if (left_q == 2'd0) begin
                            ph_q <= PH_DONE;
                        end else begin
                            left_q <= left_q - 2'd1;
                            addr_q <= step_addr(addr_q, lsb_next);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign phase   = ph_q;
    assign bitcnt  = cnt_q;
    assign rd_mode = rw_q;

    // R7: a deselected edge leaves the port waiting for an instruction, no partial bits
    a_r7_deselect_restarts: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (ph_q == PH_INSTR) && (cnt_q == '0));

    // R5: after the counted bytes nothing more is written
    a_r5_no_write_when_done: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_DONE) |-> !wr_en);

endmodule

// File: rtl/spreg_tx.sv
module spreg_tx
    import spreg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cs_n,
    input  port_cfg_t       cfg,
    input  phase_e          phase,
    input  logic            rd_mode,
    input  logic [BW-1:0]   bitcnt,
    input  logic            tx_load,
    input  logic [DW-1:0]   rd_data,
    output logic            sdio_o,
    output logic            sdio_oe,
    output logic            sdo_o,
    output logic            sdo_oe
);

    logic [DW-1:0] tx_q;
    logic          dout_q;
    logic          drv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
        end else if (tx_load) begin
            tx_q <= rd_data;
        end
    end

    // launch on the falling edge so the bit is settled for the host's rising edge
    always_ff @(negedge clk) begin
        if (rst) begin
            dout_q <= 1'b0;
            drv_q  <= 1'b0;
        end else begin
            drv_q  <= !cs_n && (phase == PH_DATA) && rd_mode;
            dout_q <= cfg.lsb_first ? tx_q[bitcnt] : tx_q[~bitcnt];
        end
    end

    assign sdio_o  = dout_q;
    assign sdo_o   = dout_q;
    assign sdio_oe = drv_q && !cs_n && cfg.three_wire;
    assign sdo_oe  = drv_q && !cs_n && !cfg.three_wire;

endmodule

// File: rtl/spreg_port.sv
module spreg_port
    import spreg_pkg::*;
(
    input  logic                sclk,
    input  logic                rst,
    input  logic                cs_n,
    input  logic                sdio_i,
    output logic                sdio_o,
    output logic                sdio_oe,
    output logic                sdo_o,
    output logic                sdo_oe,
    output logic [NREG*DW-1:0]  regs_flat
);

    logic            wr_en;
    logic [AW-1:0]   wr_addr;
    logic [DW-1:0]   wr_data;
    logic [AW-1:0]   rd_addr;
    logic [DW-1:0]   rd_data;
    logic [DW-1:0]   cfg_byte;
    logic            tx_load;
    phase_e          phase;
    logic [BW-1:0]   bitcnt;
    logic            rd_mode;
    port_cfg_t       cfg;

    assign cfg = decode_cfg(cfg_byte);

    spreg_ctrl u_ctrl (
        .clk     (sclk),
        .rst     (rst),
        .cs_n    (cs_n),
        .din     (sdio_i),
        .cfg     (cfg),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .tx_load (tx_load),
        .phase   (phase),
        .bitcnt  (bitcnt),
        .rd_mode (rd_mode)
    );

    spreg_bank u_bank (
        .clk       (sclk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .cfg_byte  (cfg_byte),
        .regs_flat (regs_flat)
    );

    spreg_tx u_tx (
        .clk     (sclk),
        .rst     (rst),
        .cs_n    (cs_n),
        .cfg     (cfg),
        .phase   (phase),
        .rd_mode (rd_mode),
        .bitcnt  (bitcnt),
        .tx_load (tx_load),
        .rd_data (rd_data),
        .sdio_o  (sdio_o),
        .sdio_oe (sdio_oe),
        .sdo_o   (sdo_o),
        .sdo_oe  (sdo_oe)
    );

endmodule

// File: tb/spreg_port_bench.sv
module spreg_port_bench;

    localparam int CLK_P = 20;

    logic         sclk = 1'b0;
    logic         rst = 1'b1;
    logic         cs_n = 1'b1;
    logic         sdio_i = 1'b0;
    logic         sdio_o, sdio_oe, sdo_o, sdo_oe;
    logic [255:0] regs_flat;

    int  n_checks = 0;
    int  n_errors = 0;
    int  oe_bad = 0;
    bit  done = 0;

    // bench model of the register bank and port configuration
    logic [7:0] exp_r [32];
    bit         cur_lsb = 0;
    bit         cur3w = 0;
    logic [7:0] wdat [4];
    logic [7:0] rdat [4];

    spreg_port u_spreg_port (
        .sclk      (sclk),
        .rst       (rst),
        .cs_n      (cs_n),
        .sdio_i    (sdio_i),
        .sdio_o    (sdio_o),
        .sdio_oe   (sdio_oe),
        .sdo_o     (sdo_o),
        .sdo_oe    (sdo_oe),
        .regs_flat (regs_flat)
    );

    always #(CLK_P/2) sclk = ~sclk;

    function automatic logic [7:0] dflt(input int k);
        int v;
        v = (k * 17) % 256;
        return (k == 0) ? 8'h00 : 8'(v);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic chk_bank(input string req);
        int bad = 0;
        int first = -1;
        for (int k = 0; k < 32; k++) begin
            if (regs_flat[k*8 +: 8] !== exp_r[k]) begin
                bad++;
                if (first < 0) first = k;
            end
        end
        n_checks++;
        if (bad != 0) begin
            n_errors++;
            $display("FAIL %s: reg %0d got %02h expected %02h (%0d mismatches)",
                     req, first, regs_flat[first*8 +: 8], exp_r[first], bad);
        end
    endtask

    task automatic send_byte(input logic [7:0] v, input bit lsb, input int nbits,
                             input bit exp_drv, output logic [7:0] got);
        logic b;
        got = 8'h00;
        for (int i = 0; i < nbits; i++) begin
            @(negedge sclk);
            #1;
            cs_n   = 1'b0;
            sdio_i = lsb ? v[i] : v[7-i];
            #(CLK_P/4);
            if (sdio_oe !== (exp_drv && cur3w) || sdo_oe !== (exp_drv && !cur3w)) oe_bad++;
            b = cur3w ? sdio_o : sdo_o;
            if (lsb) got[i] = b; else got[7-i] = b;
        end
    endtask

    // one framed access; flip sends every bit in the opposite order to the model's
    task automatic xfer(input bit rw, input int cnt, input logic [4:0] a,
                        input int extra, input int abort_bits, input bit flip);
        logic [7:0] ins;
        logic [7:0] got;
        logic [7:0] v;
        logic [4:0] ad;
        ins = {rw, 2'(cnt - 1), a};
        send_byte(ins, cur_lsb ^ flip, 8, 1'b0, got);
        ad = a;
        for (int b = 0; b < cnt; b++) begin
            if (abort_bits >= 0) begin
                send_byte(wdat[b], cur_lsb ^ flip, abort_bits, 1'b0, got);
                break;
            end
            send_byte(wdat[b], cur_lsb ^ flip, 8, rw, got);
            rdat[b] = got;
            if (!rw) begin
                if (ad == 5'd0) begin
                    v = {wdat[b][7:3], wdat[b][5], wdat[b][6], wdat[b][7]};
                    cur_lsb = v[6];
                    cur3w   = v[7];
                    if (v[5]) begin
                        for (int k = 1; k < 32; k++) exp_r[k] = dflt(k);
                        v[5] = 1'b0;
                        v[2] = 1'b0;
                    end
                    exp_r[0] = v;
                end else begin
                    exp_r[ad] = wdat[b];
                end
            end
            ad = cur_lsb ? ad + 5'd1 : ad - 5'd1;
        end
        for (int e = 0; e < extra; e++) send_byte(8'hFF, cur_lsb, 8, 1'b0, got);
        @(negedge sclk);
        #1;
        cs_n = 1'b1;
        repeat (2) @(negedge sclk);
    endtask

    task automatic t_reset;
        for (int k = 0; k < 32; k++) exp_r[k] = dflt(k);
        rst = 1'b1;
        repeat (3) @(negedge sclk);
        #1;
        rst = 1'b0;
        repeat (2) @(negedge sclk);
        #(CLK_P/4);
        chk_bank("R1 reset defaults / R11 view");
        chk("R2 no drive after reset", {6'b0, sdio_oe, sdo_oe}, 8'h00);
    endtask

    task automatic t_single;
        oe_bad = 0;
        wdat[0] = 8'h3C;
        xfer(1'b0, 1, 5'd5, 0, -1, 1'b0);
        chk_bank("R3 single write");
        xfer(1'b1, 1, 5'd5, 0, -1, 1'b0);
        chk("R3 single read", rdat[0], 8'h3C);
        chk("R4 4-wire enables", 8'(oe_bad), 8'h00);
    endtask

    task automatic t_msb_multi;
        oe_bad = 0;
        wdat[0] = 8'hA1; wdat[1] = 8'hB2; wdat[2] = 8'hC3; wdat[3] = 8'hD4;
        xfer(1'b0, 4, 5'd10, 0, -1, 1'b0);
        chk_bank("R6 msb-first decrementing write");
        chk("R6 msb reg7", exp_r[7], 8'hD4);
        xfer(1'b1, 4, 5'd10, 0, -1, 1'b0);
        for (int b = 0; b < 4; b++) chk("R6 msb multibyte read", rdat[b], exp_r[10-b]);
        chk("R2 launch on falling edge enables", 8'(oe_bad), 8'h00);
    endtask

    task automatic t_msb_wrap;
        wdat[0] = 8'h5A; wdat[1] = 8'h00; wdat[2] = 8'h77;
        xfer(1'b0, 3, 5'd1, 0, -1, 1'b0);
        chk_bank("R6 msb wrap 00h to 1Fh");
        chk("R6 reg31 after wrap", regs_flat[31*8 +: 8], 8'h77);
    endtask

    task automatic t_overrun;
        oe_bad = 0;
        wdat[0] = 8'h99;
        xfer(1'b0, 1, 5'd12, 1, -1, 1'b0);
        chk_bank("R5 extra bits ignored");
        chk("R5 reg11 untouched", regs_flat[11*8 +: 8], 8'hBB);
        chk("R5 no drive in overrun", 8'(oe_bad), 8'h00);
    endtask

    task automatic t_abort;
        wdat[0] = 8'h66;
        xfer(1'b0, 1, 5'd13, 0, 5, 1'b0);
        chk_bank("R7 partial byte discarded");
        xfer(1'b1, 1, 5'd13, 0, -1, 1'b0);
        chk("R7 fresh instruction after abort", rdat[0], 8'hDD);
    endtask

    task automatic t_switch_mid;
        wdat[0] = 8'h40; wdat[1] = 8'h2D;
        xfer(1'b0, 2, 5'd0, 0, -1, 1'b0);
        chk("R8 cfg stored with mirror", regs_flat[7:0], 8'h42);
        chk("R8 next byte lsb-first, address up", regs_flat[15:8], 8'h2D);
        chk_bank("R8 mid-access switch");
    endtask

    task automatic t_lsb_multi;
        oe_bad = 0;
        wdat[0] = 8'h13; wdat[1] = 8'h24; wdat[2] = 8'h40;
        xfer(1'b0, 3, 5'd30, 0, -1, 1'b0);
        chk_bank("R6 lsb wrap 1Fh to 00h");
        xfer(1'b1, 3, 5'd30, 0, -1, 1'b0);
        chk("R6 lsb read 30", rdat[0], 8'h13);
        chk("R6 lsb read 31", rdat[1], 8'h24);
        chk("R6 lsb read 0", rdat[2], 8'h42);
        chk("R4 enables lsb read", 8'(oe_bad), 8'h00);
    endtask

    task automatic t_three_wire;
        oe_bad = 0;
        wdat[0] = 8'hC3;
        xfer(1'b0, 1, 5'd0, 0, -1, 1'b0);
        chk("R4 3-wire cfg", regs_flat[7:0], 8'hC3);
        xfer(1'b1, 1, 5'd7, 0, -1, 1'b0);
        chk("R4 3-wire read data", rdat[0], exp_r[7]);
        chk("R4 3-wire enables", 8'(oe_bad), 8'h00);
    endtask

    task automatic t_soft_reset;
        // palindrome 11100111 sent in the order opposite to the port's
        wdat[0] = 8'hE7;
        xfer(1'b0, 1, 5'd0, 0, -1, 1'b1);
        chk("R9 reg0 kept, reset bits cleared", regs_flat[7:0], 8'hC3);
        chk_bank("R9 soft reset restores bank / R10 recovery");
        wdat[0] = 8'h00;
        xfer(1'b0, 1, 5'd0, 0, -1, 1'b1);
        chk("R10 recovered to msb 4-wire", regs_flat[7:0], 8'h00);
        oe_bad = 0;
        xfer(1'b1, 1, 5'd5, 0, -1, 1'b0);
        chk("R10 read after recovery", rdat[0], 8'h55);
        chk("R10 enables after recovery", 8'(oe_bad), 8'h00);
        #(CLK_P/4);
        chk("R2 idle hi-z", {6'b0, sdio_oe, sdo_oe}, 8'h00);
    endtask

    initial begin
        t_reset();
        t_single();
        t_msb_multi();
        t_msb_wrap();
        t_overrun();
        t_abort();
        t_switch_mid();
        t_lsb_multi();
        t_three_wire();
        t_soft_reset();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge sclk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule